// File: doc/BRIEF.md
# Serial Audio Receiver

This block turns a slave-mode serial audio stream into 24-bit channel samples. It watches a bit clock, a frame clock and six serial data lines, all sampled in the system clock domain, and rebuilds up to twelve channel words. Two framing families are supported. In the stereo family, every data line carries a left and a right word per frame, and the frame clock is a square wave whose level selects the side. In the time-division family, only line 0 is used: a frame holds 4, 8 or 16 slots of 32 bit clocks each, marked by a one-bit frame pulse or by a half-duty frame clock.

Each completed word is handed out on a single sample port as a one-cycle strobe with a channel number and the 24 data bits. When the six lines complete their words together, the words leave on consecutive system clocks in ascending channel order. The format selects are static while out of reset. They are changed only while reset is held.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, smp_valid, smp_chan and smp_data are 0. No word is delivered from a half-frame or frame whose opening frame-clock edge was not seen after reset.
- R2: The frame clock and the data lines are read on the rising edges of the bit clock. Bit clock high and low phases each last at least two system clock cycles.
- R3: With fmt_sel = 00 (I2S), the MSB arrives on the bit clock after the one that first shows a new frame-clock level. Frame clock low is the left side. A half-frame needs at least 25 bit clocks to give a word.
- R4: With fmt_sel = 01 (left-justified), the MSB arrives on the bit clock that first shows a new frame-clock level. Frame clock high is the left side. A half-frame needs at least 24 bit clocks.
- R5: With fmt_sel = 10 (right-justified), the word is the last 24 bits before the next frame-clock change, and it is delivered after that change. Frame clock high is the left side. A half-frame shorter than 24 bit clocks gives no word.
- R6: In the stereo formats, line k carries channel 2k on the left side and 2k+1 on the right side. The six words of one half-frame appear on consecutive clocks, with the channel number rising by 2 each time.
- R7: With fmt_sel = 11 (TDM), tdm_sel 00, 01, 10 and 11 select 4 slots with a pulse, 8 slots with a pulse, 16 slots with a pulse, and 8 slots with a half-duty frame clock. A frame starts on the bit clock where the frame clock is first seen high after being low. Slot s spans bits 32s to 32s+31 from that bit, and its sample is the first 24 bits, MSB first. The channel number is s. Two words are never delivered on adjacent cycles.
- R8: In TDM, only sdata[0] is used. sdata[5:1] have no effect on the outputs.
- R9: In TDM, slots numbered 12 or above, and slots at or past the selected slot count, are dropped.
- R10: When a frame-clock event comes before a word's last bit, that word is not delivered, in any format.
- R11: smp_data carries the received 24 bits unchanged, with the first received bit as bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Format: 00 I2S, 01 left-justified, 10 right-justified, 11 TDM |
| tdm_sel | input | 2 | TDM variant: 00 4-slot, 01 8-slot, 10 16-slot, 11 8-slot half duty |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Frame clock or frame pulse |
| sdata | input | 6 | Serial data lines |
| smp_valid | output | 1 | One-cycle strobe for a delivered word |
| smp_chan | output | 4 | Channel number of the delivered word |
| smp_data | output | 24 | Delivered sample |

## Verification
Some properties are checked on every cycle. Every delivered channel number is below twelve. Lines other than line 0 never hold a pending word in TDM. Back-to-back stereo deliveries step the channel by two. TDM deliveries never occur on adjacent cycles. The bench scenarios are needed for the rest. These are the exact bit alignment of each justification, the left/right side mapping, and the boundary half-frame lengths of 24 and 25 bit clocks. They also cover the slot counts and the half-duty frame clock, dropping of slots beyond channel 12 and of partial slots, and the rule that no word is taken before the first frame edge after reset.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int WORD_W    = 24;
    localparam int LANES     = 6;
    localparam int NUM_CH    = 12;
    localparam int SLOT_W    = 32;
    localparam int MAX_SLOTS = 16;
    localparam int CH_W      = $clog2(MAX_SLOTS);

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_TDM = 2'b11
    } fmt_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int LANES = sar_pkg::LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fclk,
    input  logic [LANES-1:0] sdata,
    output logic             tick,
    output logic             fclk_smp,
    output logic [LANES-1:0] sd_smp
);
    typedef struct packed {
        logic             bclk_a;
        logic             bclk_b;
        logic             fclk;
        logic [LANES-1:0] sd;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.bclk_a = bclk;
        s_d.bclk_b = s_q.bclk_a;
        s_d.fclk   = fclk;
        s_d.sd     = sdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // rising bit-clock edge seen this cycle; frame/data sampled alongside it
    assign tick     = s_q.bclk_a & ~s_q.bclk_b;
    assign fclk_smp = s_q.fclk;
    assign sd_smp   = s_q.sd;
endmodule

// File: rtl/sar_framer.sv
module sar_framer #(
    parameter int WORD_W    = sar_pkg::WORD_W,
    parameter int SLOT_W    = sar_pkg::SLOT_W,
    parameter int MAX_SLOTS = sar_pkg::MAX_SLOTS,
    parameter int NUM_CH    = sar_pkg::NUM_CH
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic                           fclk_smp,
    input  sar_pkg::fmt_e                  fmt,
    input  logic [1:0]                     tdm_sel,
    output logic                           cap_stereo,
    output logic                           cap_tdm,
    output logic                           use_old,
    output logic                           side,
    output logic [$clog2(MAX_SLOTS)-1:0]   slot
);
    import sar_pkg::*;

    localparam int SLOT_LOG = $clog2(SLOT_W);
    localparam int SCH_W    = $clog2(MAX_SLOTS);
    localparam int CNT_W    = SLOT_LOG + SCH_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [SCH_W:0]   CH_LIMIT = (SCH_W+1)'(NUM_CH);

    typedef struct packed {
        logic             prev;
        logic             primed;
        logic             synced;
        logic [CNT_W-1:0] cnt;
    } frm_t;

    frm_t s_d, s_q;

    logic             is_tdm;
    logic             fedge;
    logic [CNT_W-1:0] cnt_new;
    logic [SCH_W:0]   nslots;
    logic             in_slot;
    logic             cap_i2s, cap_lj, cap_rj;

    always_comb begin
        is_tdm  = (fmt == FMT_TDM);
        fedge   = tick & s_q.primed &
                  (is_tdm ? (fclk_smp & ~s_q.prev) : (fclk_smp ^ s_q.prev));
        cnt_new = fedge ? '0 : ((s_q.cnt == CNT_MAX) ? s_q.cnt : s_q.cnt + 1'b1);

        s_d = s_q;
        if (tick) begin
            s_d.prev   = fclk_smp;
            s_d.primed = 1'b1;
            s_d.synced = s_q.synced | fedge;
            s_d.cnt    = cnt_new;
        end

        case (tdm_sel)
            2'b00:   nslots = (SCH_W+1)'(4);
            2'b10:   nslots = (SCH_W+1)'(16);
            default: nslots = (SCH_W+1)'(8);
        endcase

        slot    = cnt_new[CNT_W-1:SLOT_LOG];
        in_slot = (cnt_new[SLOT_LOG-1:0] == SLOT_LOG'(WORD_W-1));

        cap_tdm = tick & s_q.synced & is_tdm & in_slot &
                  ({1'b0, slot} < nslots) & ({1'b0, slot} < CH_LIMIT);
        cap_i2s = tick & s_q.synced & (fmt == FMT_I2S) & (cnt_new == CNT_W'(WORD_W));
        cap_lj  = tick & s_q.synced & (fmt == FMT_LJ)  & (cnt_new == CNT_W'(WORD_W-1));
        cap_rj  = fedge & s_q.synced & (fmt == FMT_RJ) & (s_q.cnt >= CNT_W'(WORD_W-1));

        cap_stereo = cap_i2s | cap_lj | cap_rj;
        use_old    = cap_rj;

        case (fmt)
            FMT_I2S: side = fclk_smp;
            FMT_LJ:  side = ~fclk_smp;
            FMT_RJ:  side = ~s_q.prev;
            default: side = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // a right-justified word is only ever taken at a level change of the frame clock
    AST_RJ_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stereo && fmt == FMT_RJ) |-> (fclk_smp != s_q.prev)) else $error("rj capture off edge"); // R5
endmodule

// File: rtl/sar_lane.sv
module sar_lane #(
    parameter int WORD_W = sar_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sd,
    input  logic              cap,
    input  logic              use_old,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] hold;
    } lane_t;

    lane_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) s_d.sr = {s_q.sr[WORD_W-2:0], sd};
        if (cap)  s_d.hold = use_old ? s_q.sr : s_d.sr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word = s_q.hold;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int LANES     = sar_pkg::LANES,
    parameter int WORD_W    = sar_pkg::WORD_W,
    parameter int NUM_CH    = sar_pkg::NUM_CH,
    parameter int SLOT_W    = sar_pkg::SLOT_W,
    parameter int MAX_SLOTS = sar_pkg::MAX_SLOTS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   fmt_sel,
    input  logic [1:0]                   tdm_sel,
    input  logic                         bclk,
    input  logic                         fclk,
    input  logic [LANES-1:0]             sdata,
    output logic                         smp_valid,
    output logic [$clog2(MAX_SLOTS)-1:0] smp_chan,
    output logic [WORD_W-1:0]            smp_data
);
    import sar_pkg::*;

    localparam int OCH_W = $clog2(MAX_SLOTS);

    fmt_e               fmt;
    logic               tick;
    logic               fclk_smp;
    logic [LANES-1:0]   sd_smp;
    logic               cap_stereo, cap_tdm, use_old, side;
    logic [OCH_W-1:0]   slot;
    logic [LANES-1:0]   cap_lane;
    logic [WORD_W-1:0]  lane_word [LANES];

    assign fmt = fmt_e'(fmt_sel);

    sar_sync #(.LANES(LANES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fclk     (fclk),
        .sdata    (sdata),
        .tick     (tick),
        .fclk_smp (fclk_smp),
        .sd_smp   (sd_smp)
    );

    sar_framer #(
        .WORD_W    (WORD_W),
        .SLOT_W    (SLOT_W),
        .MAX_SLOTS (MAX_SLOTS),
        .NUM_CH    (NUM_CH)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fclk_smp   (fclk_smp),
        .fmt        (fmt),
        .tdm_sel    (tdm_sel),
        .cap_stereo (cap_stereo),
        .cap_tdm    (cap_tdm),
        .use_old    (use_old),
        .side       (side),
        .slot       (slot)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign cap_lane[g] = cap_stereo | cap_tdm;
        end else begin : g_rest
            assign cap_lane[g] = cap_stereo;
        end
        sar_lane #(.WORD_W(WORD_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .sd      (sd_smp[g]),
            .cap     (cap_lane[g]),
            .use_old (use_old),
            .word    (lane_word[g])
        );
    end

    typedef struct packed {
        logic [LANES-1:0]            pend;
        logic [LANES-1:0][OCH_W-1:0] chan;
        logic                        valid;
        logic [OCH_W-1:0]            out_chan;
        logic [WORD_W-1:0]           out_data;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        logic found;
        s_d       = s_q;
        s_d.valid = 1'b0;
        found     = 1'b0;
        // lowest pending line drains first: ascending channel order
        for (int i = 0; i < LANES; i++) begin
            if (s_q.pend[i] && !found) begin
                found        = 1'b1;
                s_d.valid    = 1'b1;
                s_d.out_chan = s_q.chan[i];
                s_d.out_data = lane_word[i];
                s_d.pend[i]  = 1'b0;
            end
        end
        for (int i = 0; i < LANES; i++) begin
            if (cap_lane[i]) begin
                s_d.pend[i] = 1'b1;
                s_d.chan[i] = cap_tdm ? slot
                                      : (OCH_W'(2 * i) | {{(OCH_W-1){1'b0}}, side});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_valid = s_q.valid;
    assign smp_chan  = s_q.out_chan;
    assign smp_data  = s_q.out_data;

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (smp_chan < OCH_W'(NUM_CH))) else $error("channel out of range"); // R9
    AST_TDM_LINE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_TDM) |-> (s_q.pend[LANES-1:1] == '0)) else $error("tdm used extra line"); // R8
    AST_STEREO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt != FMT_TDM && smp_valid && $past(smp_valid)) |->
        (smp_chan == $past(smp_chan) + OCH_W'(2))) else $error("stereo order broken"); // R6
    AST_TDM_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_TDM && smp_valid) |=> !smp_valid) else $error("tdm words adjacent"); // R7
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  tdm_sel = 2'b00;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic [5:0]  sdata = '0;
    logic        smp_valid;
    logic [3:0]  smp_chan;
    logic [23:0] smp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          exp_n = 0;
    int          exp_chan [512];
    logic [23:0] exp_data [512];
    int          rcv_n = 0;
    int          rcv_chan [512];
    logic [23:0] rcv_data [512];

    always #5 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .tdm_sel   (tdm_sel),
        .bclk      (bclk),
        .fclk      (fclk),
        .sdata     (sdata),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data)
    );

    always @(negedge clk) begin
        if (smp_valid) begin
            if (rcv_n < 512) begin
                rcv_chan[rcv_n] = int'(smp_chan);
                rcv_data[rcv_n] = smp_data;
            end
            rcv_n = rcv_n + 1;
        end
    end

    // fields: [25:24] format, [23:22] tdm variant, [21:12] length, [11:8] frames, [7:0] seed
    localparam int NV = 15;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 2'd0, 10'd32, 4'd2, 8'hC3},  // R3 R6
        {2'd1, 2'd0, 10'd32, 4'd2, 8'hA5},  // R4 R6
        {2'd2, 2'd0, 10'd32, 4'd2, 8'h96},  // R5 R6
        {2'd0, 2'd0, 10'd24, 4'd1, 8'h11},  // R3 R10: 24 bits too short
        {2'd0, 2'd0, 10'd25, 4'd1, 8'hE7},  // R3 boundary
        {2'd1, 2'd0, 10'd24, 4'd1, 8'h4B},  // R4 boundary
        {2'd2, 2'd0, 10'd24, 4'd1, 8'hF0},  // R5 boundary
        {2'd2, 2'd0, 10'd20, 4'd1, 8'h2C},  // R5 R10 short
        {2'd1, 2'd0, 10'd20, 4'd1, 8'h77},  // R4 R10 short
        {2'd2, 2'd0, 10'd48, 4'd1, 8'h8E},  // R5 long half
        {2'd3, 2'd0, 10'd0,  4'd2, 8'hD2},  // R7 four slots
        {2'd3, 2'd1, 10'd0,  4'd1, 8'h39},  // R7 eight slots
        {2'd3, 2'd2, 10'd0,  4'd1, 8'hB4},  // R7 R9 sixteen slots
        {2'd3, 2'd3, 10'd0,  4'd2, 8'h6A},  // R7 half duty
        {2'd3, 2'd0, 10'd80, 4'd2, 8'h5F}   // R10 partial slot
    };

    function automatic logic [23:0] mkword(input logic [7:0] seed, input int f, input int c);
        logic [3:0] cc;
        logic [3:0] ff;
        cc = c[3:0];
        ff = f[3:0];
        return {seed ^ {cc, ff}, 16'h5A3C ^ {cc, ~cc, ff, cc}};
    endfunction

    task automatic push(input int c, input logic [23:0] d);
        if (exp_n < 512) begin
            exp_chan[exp_n] = c;
            exp_data[exp_n] = d;
        end
        exp_n = exp_n + 1;
    endtask

    task automatic send_bit(input logic fc, input logic [5:0] sd);
        @(negedge clk);
        fclk = fc;
        sdata = sd;
        bclk = 1'b0;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] t);
        @(negedge clk);
        rst_n = 1'b0;
        bclk = 1'b0;
        fmt_sel = f;
        tdm_sel = t;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_stereo(input logic [1:0] f, input int len, input int frames,
                              input logic [7:0] seed, input bit leadin);
        bit emit;
        logic lvl0;
        emit = (f == 2'd0) ? (len >= 25) : (len >= 24);
        lvl0 = (f == 2'd0) ? 1'b0 : 1'b1;
        if (leadin) begin
            repeat (3) send_bit(~lvl0, 6'd0);
        end
        for (int h = 0; h < 2 * frames; h++) begin
            int sidev;
            logic lvl;
            sidev = h % 2;
            lvl = (h % 2 == 0) ? lvl0 : ~lvl0;
            if (emit && (leadin || h > 0)) begin
                for (int k = 0; k < 6; k++) push(2 * k + sidev, mkword(seed, h / 2, 2 * k + sidev));
            end
            for (int b = 0; b < len; b++) begin
                logic [5:0] sd;
                for (int k = 0; k < 6; k++) begin
                    logic [23:0] w;
                    w = mkword(seed, h / 2, 2 * k + sidev);
                    sd[k] = 1'b0;
                    if (f == 2'd0 && b >= 1 && b <= 24) sd[k] = w[24 - b];
                    if (f == 2'd1 && b < 24) sd[k] = w[23 - b];
                    if (f == 2'd2 && len >= 24 && b >= len - 24) sd[k] = w[len - 1 - b];
                end
                send_bit(lvl, sd);
            end
        end
        repeat (4) send_bit(lvl0, 6'd0);
        repeat (30) @(negedge clk);
    endtask

    task automatic run_tdm(input logic [1:0] t, input int len, input int frames, input logic [7:0] seed);
        int ns;
        int fb;
        ns = (t == 2'd0) ? 4 : ((t == 2'd2) ? 16 : 8);
        fb = (len == 0) ? ns * 32 : len;
        repeat (3) send_bit(1'b0, 6'd0);
        for (int f = 0; f < frames; f++) begin
            for (int s = 0; s < ns && s < 12; s++) begin
                if (32 * s + 24 <= fb) push(s, mkword(seed, f, s));
            end
            for (int b = 0; b < fb; b++) begin
                logic [5:0] sd;
                logic fc;
                logic [23:0] w;
                w = mkword(seed, f, b / 32);
                fc = (t == 2'd3) ? (b < fb / 2) : (b == 0);
                sd[5:1] = 5'(b * 7 + 3);   // lines other than 0 carry noise in TDM
                sd[0] = ((b % 32) < 24) ? w[23 - (b % 32)] : 1'b0;
                send_bit(fc, sd);
            end
        end
        repeat (4) send_bit(1'b0, 6'd0);
        repeat (30) @(negedge clk);
    endtask

    task automatic check_run(input string tag, input int base);
        int got;
        got = rcv_n - base;
        checks++;
        if (got != exp_n) begin
            errors++;
            $display("FAIL %s word count: actual %0d expected %0d", tag, got, exp_n);
        end
        for (int i = 0; i < exp_n && i < got && i < 512 && base + i < 512; i++) begin
            checks++;
            if (rcv_chan[base + i] != exp_chan[i]) begin
                errors++;
                $display("FAIL %s R6 channel at word %0d: actual %0d expected %0d",
                         tag, i, rcv_chan[base + i], exp_chan[i]);
            end
            checks++;
            if (rcv_data[base + i] != exp_data[i]) begin
                errors++;
                $display("FAIL %s R11 R2 data at word %0d: actual %h expected %h",
                         tag, i, rcv_data[base + i], exp_data[i]);
            end
        end
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    initial begin : main
        int base;
        string tag;
        // R1: reset state of the sample port
        do_reset(2'd0, 2'd0);
        check_val("R1 smp_valid after reset", 32'(smp_valid), 32'd0);
        check_val("R1 smp_chan after reset", 32'(smp_chan), 32'd0);
        check_val("R1 smp_data after reset", 32'(smp_data), 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] f;
            logic [1:0] t;
            int len;
            int frames;
            logic [7:0] seed;
            f      = VEC[v][25:24];
            t      = VEC[v][23:22];
            len    = int'(VEC[v][21:12]);
            frames = int'(VEC[v][11:8]);
            seed   = VEC[v][7:0];
            do_reset(f, t);
            exp_n = 0;
            base = rcv_n;
            case (f)
                2'd0:    tag = "R3 R10 vector";
                2'd1:    tag = "R4 R10 vector";
                2'd2:    tag = "R5 R10 vector";
                default: tag = "R7 R8 R9 R10 vector";
            endcase
            if (f == 2'd3) run_tdm(t, len, frames, seed);
            else           run_stereo(f, len, frames, seed, 1'b1);
            check_run($sformatf("%s %0d", tag, v), base);
        end

        // R1: without a lead-in edge the first half-frame is not taken
        do_reset(2'd0, 2'd0);
        exp_n = 0;
        base = rcv_n;
        run_stereo(2'd0, 32, 1, 8'h3D, 1'b0);
        check_run("R1 no opening edge", base);

        // R1: reset in mid stream yields nothing, then reception resumes
        do_reset(2'd1, 2'd0);
        base = rcv_n;
        repeat (3) send_bit(1'b0, 6'd0);
        for (int b = 0; b < 20; b++) send_bit(1'b1, 6'h2A);
        @(negedge clk);
        rst_n = 1'b0;
        for (int b = 0; b < 10; b++) send_bit(1'b1, 6'h15);
        check_val("R1 outputs during reset", 32'(rcv_n - base), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_n = 0;
        base = rcv_n;
        run_stereo(2'd1, 32, 1, 8'h9B, 1'b1);
        check_run("R1 after mid-stream reset", base);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule